// File: doc/BRIEF.md
# Polarity-Controlled 1-of-8 Decoder

This block is a purely combinational binary decoder and demultiplexer. It is built from 8-line slices. Inside each slice, a 3-bit address picks one of eight output lines. The picked line is driven to the active level and the other seven are driven to the inactive level. A run-time polarity input chooses whether "active" means high or low. The inactive level always equals the polarity input.

Four input enables gate the decode: two active-low and two active-high. When any of them is not asserted, every line rests at the inactive level. This lets one enable carry a data stream, so the block also works as a demultiplexer. Two active-low output enables control the bus drive, which is exposed as a per-bit drive-enable vector beside the data vector. When either output enable is high, the whole bus is released. The data vector keeps its decoded value in that case.

The top level cascades `SLICES` slices; the parameter must be a power of two. The upper address bits pick exactly one slice through that slice's active-high enable. The polarity, the input enables and the output enables are shared by all slices. With the default of four slices the block is a 1-of-32 decoder. With one slice it is the plain 1-of-8 decoder.

Top module: `pdec_cascade`

## Requirements
- R1: With the decode open, address value n makes output line n (bit n of `data_o`) take the active level, for every n in range.
- R2: With `pol_i` = 0 and the decode open, the selected line is 1 and every other line is 0.
- R3: With `pol_i` = 1 and the decode open, the selected line is 0 and every other line is 1.
- R4: If either bit of `oe_n_i` is 1, `drv_o` is all zeros whatever the other inputs are, and `data_o` still carries the decoded value.
- R5: If both bits of `oe_n_i` are 0, `drv_o` is all ones.
- R6: The decode is open only when `en_n_i` = 2'b00 and `en_i` = 2'b11. Otherwise every bit of `data_o` equals `pol_i`.
- R7: In the cascade, address bits [ADDR_W-1:3] pick the slice and bits [2:0] pick the line in it, so a full address m selects line m of the `8*SLICES`-bit bus, and no other line is active.
- R8: With the other enables asserted and the address held, toggling `en_i[0]` as a data input makes the selected line follow it: active when the bit is 1, inactive when it is 0. The other lines stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W (3+log2 SLICES) | Line address; the upper bits pick the slice |
| en_n_i | input | 2 | Active-low input enables |
| en_i | input | 2 | Active-high input enables; bit 0 can carry demux data |
| pol_i | input | 1 | Polarity: 0 gives an active-high select, 1 an active-low select; also the inactive level |
| oe_n_i | input | 2 | Active-low output enables |
| data_o | output | 8*SLICES | Decoded line values |
| drv_o | output | 8*SLICES | Per-bit drive enable; 1 means the line is driven |

## Verification
The bench sweeps every combination of address, enables, polarity and output enables on a four-slice and a one-slice instance.

It targets several corner cases:
- The partly asserted enable patterns. A gate built with OR instead of AND would leave a line selected when only one enable is asserted.
- The polarity flip. A design that inverts only the selected line, or leaves the idle level fixed at 0, shows a wrong inactive level once `pol_i` is 1.
- The slice boundaries at addresses 7/8, 15/16 and 23/24. A bad upper-bit select lights two slices or none there.
- Output-enable release. A design that lets the output enables clear the data vector, or reacts to only one of them, breaks R4 and R5.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int unsigned SLICE_AW = 3;
  localparam int unsigned SLICE_OW = 1 << SLICE_AW;

  typedef struct packed {
    logic [1:0] en_n;
    logic [1:0] en;
  } pdec_gate_t;

  function automatic logic gate_open(pdec_gate_t g);
    return (g.en_n == 2'b00) && (g.en == 2'b11);
  endfunction
endpackage

// File: rtl/pdec_onehot.sv
module pdec_onehot #(
  parameter int unsigned AW = 3,
  localparam int unsigned OW = 1 << AW
) (
  input  logic [AW-1:0] idx_i,
  input  logic          vld_i,
  output logic [OW-1:0] hot_o
);
  for (genvar i = 0; i < OW; i++) begin : g_line
    assign hot_o[i] = vld_i && (idx_i == AW'(i));
  end
endmodule

// File: rtl/pdec_slice.sv
module pdec_slice
  import pdec_pkg::*;
(
  input  logic [SLICE_AW-1:0] addr_i,
  input  pdec_gate_t          gate_i,
  input  logic                pol_i,
  input  logic [1:0]          oe_n_i,
  output logic [SLICE_OW-1:0] data_o,
  output logic [SLICE_OW-1:0] drv_o
);
  logic [SLICE_OW-1:0] hot;

  pdec_onehot #(.AW(SLICE_AW)) u_hot (
    .idx_i (addr_i),
    .vld_i (gate_open(gate_i)),
    .hot_o (hot)
  );

  // polarity applied after select: idle lines land on pol_i
  assign data_o = hot ^ {SLICE_OW{pol_i}};
  assign drv_o  = {SLICE_OW{~|oe_n_i}};
endmodule

// File: rtl/pdec_cascade.sv
module pdec_cascade
  import pdec_pkg::*;
#(
  parameter int unsigned SLICES = 4,
  localparam int unsigned SEL_W  = (SLICES > 1) ? $clog2(SLICES) : 1,
  localparam int unsigned ADDR_W = SLICE_AW + ((SLICES > 1) ? $clog2(SLICES) : 0),
  localparam int unsigned OUT_W  = SLICE_OW * SLICES
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        en_n_i,
  input  logic [1:0]        en_i,
  input  logic              pol_i,
  input  logic [1:0]        oe_n_i,
  output logic [OUT_W-1:0]  data_o,
  output logic [OUT_W-1:0]  drv_o
);
  logic [SLICES-1:0] slice_sel;

  if (SLICES == 1) begin : g_single
    assign slice_sel = 1'b1;
  end else begin : g_multi
    logic [SEL_W-1:0] addr_hi;
    assign addr_hi = addr_i[ADDR_W-1:SLICE_AW];
    for (genvar k = 0; k < SLICES; k++) begin : g_sel
      assign slice_sel[k] = (addr_hi == SEL_W'(k));
    end
  end

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    pdec_gate_t gate;
    assign gate.en_n = en_n_i;
    // slice select rides on the low active-high enable
    assign gate.en   = {en_i[1], en_i[0] & slice_sel[k]};

    pdec_slice u_slice (
      .addr_i (addr_i[SLICE_AW-1:0]),
      .gate_i (gate),
      .pol_i  (pol_i),
      .oe_n_i (oe_n_i),
      .data_o (data_o[k*SLICE_OW +: SLICE_OW]),
      .drv_o  (drv_o[k*SLICE_OW +: SLICE_OW])
    );
  end
endmodule

// File: rtl/pdec_chk.sv
module pdec_chk
  import pdec_pkg::*;
#(
  parameter int unsigned SLICES = 4,
  localparam int unsigned ADDR_W = SLICE_AW + ((SLICES > 1) ? $clog2(SLICES) : 0),
  localparam int unsigned OUT_W  = SLICE_OW * SLICES
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        en_n_i,
  input logic [1:0]        en_i,
  input logic              pol_i,
  input logic [1:0]        oe_n_i,
  input logic [OUT_W-1:0]  data_o,
  input logic [OUT_W-1:0]  drv_o
);
  logic open_w;
  assign open_w = (en_n_i == 2'b00) && (en_i == 2'b11);

  always_comb begin
    if (!$isunknown({addr_i, en_n_i, en_i, pol_i, oe_n_i})) begin
      // R4
      oe_release_chk: assert (!(|oe_n_i) || (drv_o == '0))
        else $error("oe_release_chk");
      // R5
      oe_drive_chk: assert ((|oe_n_i) || (&drv_o))
        else $error("oe_drive_chk");
      // R6
      gate_idle_chk: assert (open_w || (data_o == {OUT_W{pol_i}}))
        else $error("gate_idle_chk");
      // R7
      single_line_chk: assert (!open_w || ($countones(data_o ^ {OUT_W{pol_i}}) == 1))
        else $error("single_line_chk");
      // R1
      addr_line_chk: assert (!open_w || (data_o[addr_i] == !pol_i))
        else $error("addr_line_chk");
    end
  end
endmodule

bind pdec_cascade pdec_chk #(.SLICES(SLICES)) u_chk (
  .addr_i (addr_i),
  .en_n_i (en_n_i),
  .en_i   (en_i),
  .pol_i  (pol_i),
  .oe_n_i (oe_n_i),
  .data_o (data_o),
  .drv_o  (drv_o)
);

// File: tb/sim_pdec_cascade.sv
module sim_pdec_cascade;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_ni;

  logic [4:0]  addr;
  logic [1:0]  en_n, en, oe_n;
  logic        pol;
  logic [31:0] d0, v0;
  logic [7:0]  d1, v1;

  pdec_cascade u0 (
    .addr_i(addr), .en_n_i(en_n), .en_i(en), .pol_i(pol), .oe_n_i(oe_n),
    .data_o(d0), .drv_o(v0)
  );

  pdec_cascade #(.SLICES(1)) u1 (
    .addr_i(addr[2:0]), .en_n_i(en_n), .en_i(en), .pol_i(pol), .oe_n_i(oe_n),
    .data_o(d1), .drv_o(v1)
  );

  typedef struct {
    logic [3:0]  kind;  // 0 sweep, 1 address walk, 8 demux
    logic [1:0]  en_n;
    logic [1:0]  oe_n;
    logic        pol;
    logic        open;
    logic [31:0] xd0, xv0;
    logic [7:0]  xd1, xv1;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [31:0] ref_data(logic [4:0] a, logic on, logic p, int lines);
    logic [31:0] r;
    r = {32{p}};
    if (on && (int'(a) < lines)) r[a] = ~p;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] kind, logic [4:0] a, logic [1:0] e_n, logic [1:0] e,
                       logic p, logic [1:0] o_n);
    item_t it;
    logic on;
    @(posedge clk);
    addr = a; en_n = e_n; en = e; pol = p; oe_n = o_n;
    on = (e_n == 2'b00) && (e == 2'b11);
    it.kind = kind; it.en_n = e_n; it.oe_n = o_n; it.pol = p; it.open = on;
    it.xd0  = ref_data(a, on, p, 32);
    it.xv0  = (o_n == 2'b00) ? 32'hFFFF_FFFF : 32'h0;
    it.xd1  = ref_data({2'b00, a[2:0]}, on, p, 8)[7:0];
    it.xv1  = (o_n == 2'b00) ? 8'hFF : 8'h00;
    q.push_back(it);
  endtask

  // monitor: outputs settle within the driven cycle, compare on the falling edge
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      string tag;
      it = q.pop_front();
      if (it.kind == 4'd1)      tag = "R1";
      else if (it.kind == 4'd8) tag = "R8";
      else if (!it.open)        tag = "R6";
      else if (it.pol)          tag = "R3";
      else                      tag = "R2";
      chk({tag, " slice"}, {24'h0, d1}, {24'h0, it.xd1});
      chk((it.kind == 4'd0) ? "R7 cascade" : {tag, " cascade"}, d0, it.xd0);
      chk((it.oe_n != 2'b00) ? "R4 drive" : "R5 drive", v0, it.xv0);
      chk((it.oe_n != 2'b00) ? "R4 drive slice" : "R5 drive slice", {24'h0, v1}, {24'h0, it.xv1});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    addr = '0; en_n = 2'b00; en = 2'b00; pol = 1'b0; oe_n = 2'b11;
    repeat (3) @(negedge clk);
    // reset state: bus released (R4), gate closed so lines idle at pol=0 (R6)
    chk("R4 reset", v0, 32'h0);
    chk("R6 reset", d0, 32'h0);
    rst_ni = 1'b1;

    // exhaustive sweep over every input combination
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] b;
      b = 12'(i);
      drive(4'd0, b[4:0], b[9:8], b[7:6], b[5], b[11:10]);
    end

    // R1 address walk in both polarities, across slice boundaries
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 32; a++) begin
        drive(4'd1, 5'(a), 2'b00, 2'b11, 1'(p), 2'b00);
      end
    end

    // R8 demux: en_i[0] carries a bit stream, address held
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        logic bit_v;
        bit_v = 1'((8'b1011_0010 >> s) & 1);
        drive(4'd8, 5'd13, 2'b00, {1'b1, bit_v}, 1'(p), 2'b00);
      end
    end

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule